// File: doc/BRIEF.md
# Floating-Point Compare and Classify Unit

This unit evaluates one predicate operation per cycle on IEEE-754 operands. A precision flag picks single or double format. Four compare operations relate operand `a` to operand `b`: equal, greater-than, greater-or-equal and unordered. A classify operation tests operand `a` against a five-bit class mask. The answer is an 8-bit predicate that is either all ones or all zeros. A sticky-free invalid flag goes with each answer.

Comparisons are quiet. A NaN on either side makes every ordered test false, and only a signalling NaN raises the invalid flag. By default the result passes through one output register. With `REG_OUT` cleared the unit is purely combinational.

Top module: `fp_cmp_class`

## Requirements
- R1: Every result on `pred` is either 8'hFF (true) or 8'h00 (false).
- R2: Operation codes on `op`: 0 equal, 1 greater-than, 2 greater-or-equal, 3 unordered, 4 classify. Codes 5 to 7 give `pred` = 8'h00 and `invalid` = 0.
- R3: Classify is true when any selected class matches operand `a`. The class selected by each `mask` bit is: bit 0 zero of either sign, bit 1 normal, bit 2 denormal (exponent zero, mantissa non-zero), bit 3 infinity, bit 4 NaN of any kind.
- R4: Classify never raises `invalid`, whatever the operand.
- R5: Unordered is true exactly when `a` or `b` is a NaN.
- R6: Equal, greater-than and greater-or-equal are false whenever `a` or `b` is a NaN.
- R7: For non-NaN operands, greater-than is true only when a > b numerically, and greater-or-equal is true when a > b or a == b. Equal holds for identical values, and +0 equals -0.
- R8: `invalid` is 1 only when the operation is equal, greater-than or greater-or-equal and an operand is a signalling NaN, that is a NaN whose top mantissa bit is 0. Unordered never raises it.
- R9: When `dbl` = 1, operands use sign bit 63, exponent bits 62:52 and mantissa bits 51:0. When `dbl` = 0, they use sign bit 31, exponent bits 30:23 and mantissa bits 22:0, and bits 63:32 have no effect.
- R10: With `REG_OUT` = 1, results appear one clock after the inputs. Reset (`rst_n` low) forces `pred` = 8'h00 and `invalid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low reset |
| dbl | input | 1 | 1 selects double precision, 0 selects single |
| op | input | 3 | Operation code |
| a | input | 64 | First operand (the classify operand) |
| b | input | 64 | Second operand |
| mask | input | 5 | Class select for classify |
| pred | output | 8 | Predicate result |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The assertions check on every cycle that the predicate is all ones or all zeros. They also check that NaN operands force the ordered compares false, that classify and unordered stay silent on `invalid`, and that unused codes and an empty mask give false. Only the bench's sweep can show the numeric ordering of the finite, infinite and denormal values, the equality of signed zeros, the decoding of each mask bit, and the independence of single results from the upper operand half. It crosses a table of boundary values in both precisions against every operation.

// File: rtl/fp_cmp_class.sv
module fp_cmp_class #(
  parameter bit REG_OUT = 1'b1,
  parameter int SE = 8,
  parameter int SM = 23,
  parameter int DE = 11,
  parameter int DM = 52,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbl,
  input  logic [2:0]    op,
  input  logic [63:0]   a,
  input  logic [63:0]   b,
  input  logic [4:0]    mask,
  output logic [PW-1:0] pred,
  output logic          invalid
);
  localparam int SW = 1 + SE + SM;
  localparam int DW = 1 + DE + DM;
  localparam int MW = DW - 1;

  localparam logic [2:0] OP_EQ = 3'd0;
  localparam logic [2:0] OP_GT = 3'd1;
  localparam logic [2:0] OP_GE = 3'd2;
  localparam logic [2:0] OP_UO = 3'd3;
  localparam logic [2:0] OP_CL = 3'd4;

  // {snan, nan, inf, denorm, normal, zero}
  function automatic logic [5:0] kind(input logic [63:0] x, input logic dp);
    logic ea, ez, mz, qb;
    ea = dp ? &x[DW-2:DM] : &x[SW-2:SM];
    ez = dp ? ~|x[DW-2:DM] : ~|x[SW-2:SM];
    mz = dp ? ~|x[DM-1:0] : ~|x[SM-1:0];
    qb = dp ? x[DM-1] : x[SM-1];
    return {ea & ~mz & ~qb, ea & ~mz, ea & mz, ez & ~mz, ~ea & ~ez, ez & mz};
  endfunction

  logic [5:0]    ka, kb;
  logic          sa, sb;
  logic [MW-1:0] ma, mb;
  logic          any_nan, any_snan, both_zero;
  logic          eq_v, gt_v, ordered_op;
  logic          hit;
  logic          inv_d;

  assign ka = kind(a, dbl);
  assign kb = kind(b, dbl);
  assign sa = dbl ? a[DW-1] : a[SW-1];
  assign sb = dbl ? b[DW-1] : b[SW-1];
  assign ma = dbl ? a[MW-1:0] : MW'(a[SW-2:0]);
  assign mb = dbl ? b[MW-1:0] : MW'(b[SW-2:0]);

  assign any_nan   = ka[4] | kb[4];
  assign any_snan  = ka[5] | kb[5];
  assign both_zero = ka[0] & kb[0];

  assign eq_v = both_zero | ((sa == sb) && (ma == mb));
  always_comb begin
    if (both_zero)      gt_v = 1'b0;
    else if (sa != sb)  gt_v = ~sa;
    else if (!sa)       gt_v = ma > mb;
    else                gt_v = ma < mb;
  end

  assign ordered_op = (op == OP_EQ) || (op == OP_GT) || (op == OP_GE);

  always_comb begin
    unique case (op)
      OP_EQ:   hit = ~any_nan & eq_v;
      OP_GT:   hit = ~any_nan & gt_v;
      OP_GE:   hit = ~any_nan & (gt_v | eq_v);
      OP_UO:   hit = any_nan;
      OP_CL:   hit = |(mask & ka[4:0]);
      default: hit = 1'b0;
    endcase
  end

  assign inv_d = ordered_op & any_snan;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pred    <= '0;
          invalid <= 1'b0;
        end else begin
          pred    <= {PW{hit}};
          invalid <= inv_d;
        end
      end
    end else begin : g_comb
      assign pred    = {PW{hit}};
      assign invalid = inv_d;
    end
  endgenerate
endmodule

// File: rtl/fp_cmp_class_chk.sv
module fp_cmp_class_chk #(
  parameter bit REG_OUT = 1'b1,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dbl,
  input logic [2:0]    op,
  input logic [63:0]   a,
  input logic [63:0]   b,
  input logic [4:0]    mask,
  input logic [PW-1:0] pred,
  input logic          invalid
);
  logic [2:0]  op_q;
  logic [4:0]  mask_q;
  logic        nan_q;

  function automatic logic isnan(input logic [63:0] x, input logic dp);
    if (dp) return (x[62:52] == 11'h7FF) && (x[51:0] != 52'd0);
    return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
  endfunction

  generate
    if (REG_OUT) begin : g_q
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          op_q <= 3'd7; mask_q <= '0; nan_q <= 1'b0;
        end else begin
          op_q <= op; mask_q <= mask; nan_q <= isnan(a, dbl) | isnan(b, dbl);
        end
      end
    end else begin : g_d
      assign op_q   = op;
      assign mask_q = mask;
      assign nan_q  = isnan(a, dbl) | isnan(b, dbl);
    end
  endgenerate

  p_all_or_none_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pred == '0) || (pred == '1));
  p_spare_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q > 3'd4) |-> (pred == '0 && !invalid));
  p_empty_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == 3'd4 && mask_q == 5'd0) |-> (pred == '0));
  p_class_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == 3'd4) |-> !invalid);
  p_uo_nan_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == 3'd3) |-> ((pred == '1) == nan_q));
  p_nan_false_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q <= 3'd2 && nan_q) |-> (pred == '0));
  p_inv_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (op_q <= 3'd2 && nan_q));
endmodule

bind fp_cmp_class fp_cmp_class_chk #(.REG_OUT(REG_OUT), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbl(dbl), .op(op), .a(a), .b(b),
  .mask(mask), .pred(pred), .invalid(invalid)
);

// File: tb/sim_fp_cmp_class.sv
module sim_fp_cmp_class;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbl = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [63:0] a = '0, b = '0;
  logic [4:0]  mask = '0;
  logic [7:0]  pred;
  logic        invalid;

  int nvec = 0, nbad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fp_cmp_class u0 (.clk(clk), .rst_n(rst_n), .dbl(dbl), .op(op), .a(a), .b(b),
                   .mask(mask), .pred(pred), .invalid(invalid));

  localparam int NP = 13;

  function automatic logic [63:0] pat(input int i, input bit dp);
    logic [31:0] s;
    logic [63:0] d;
    case (i)
      0: begin s = 32'h0000_0000; d = 64'h0000_0000_0000_0000; end
      1: begin s = 32'h8000_0000; d = 64'h8000_0000_0000_0000; end
      2: begin s = 32'h0000_0001; d = 64'h0000_0000_0000_0001; end
      3: begin s = 32'h8000_0001; d = 64'h8000_0000_0000_0001; end
      4: begin s = 32'h3F80_0000; d = 64'h3FF0_0000_0000_0000; end
      5: begin s = 32'hBF80_0000; d = 64'hBFF0_0000_0000_0000; end
      6: begin s = 32'h4000_0000; d = 64'h4000_0000_0000_0000; end
      7: begin s = 32'h7F7F_FFFF; d = 64'h7FEF_FFFF_FFFF_FFFF; end
      8: begin s = 32'h7F80_0000; d = 64'h7FF0_0000_0000_0000; end
      9: begin s = 32'hFF80_0000; d = 64'hFFF0_0000_0000_0000; end
      10: begin s = 32'h7FC0_0000; d = 64'h7FF8_0000_0000_0000; end
      11: begin s = 32'h7F80_0001; d = 64'h7FF0_0000_0000_0001; end
      default: begin s = 32'hFFC0_0000; d = 64'hFFF8_0000_0000_0000; end
    endcase
    // single operands carry junk in the upper half (R9)
    return dp ? d : {32'hA5C3_0000 | 32'(i * 7919), s};
  endfunction

  // class code: 0 zero, 1 normal, 2 denormal, 3 inf, 4 qnan, 5 snan
  function automatic int cls(input logic [63:0] x, input bit dp);
    int e, emax; logic mz, q;
    e    = dp ? int'(x[62:52]) : int'(x[30:23]);
    emax = dp ? 2047 : 255;
    mz   = dp ? (x[51:0] == 0) : (x[22:0] == 0);
    q    = dp ? x[51] : x[22];
    if (e == 0) return mz ? 0 : 2;
    if (e == emax) return mz ? 3 : (q ? 4 : 5);
    return 1;
  endfunction

  function automatic real val(input logic [63:0] x, input bit dp);
    real v; int e; longint m;
    if (dp) return $bitstoreal(x);
    e = int'(x[30:23]); m = longint'(x[22:0]);
    if (e == 255) v = 1.0e300;
    else if (e == 0) v = real'(m) * 2.0 ** (-149);
    else v = real'(m + 8388608) * 2.0 ** (e - 150);
    return x[31] ? -v : v;
  endfunction

  task automatic check(input string req, input logic [7:0] ep, input logic ei);
    nvec++;
    if (pred !== ep || invalid !== ei) begin
      nbad++;
      $display("FAIL %s dbl=%0b op=%0d a=%h b=%h mask=%b: got pred=%h inv=%b, expected pred=%h inv=%b",
               req, dbl, op, a, b, mask, pred, invalid, ep, ei);
    end
  endtask

  task automatic apply(input bit dp, input logic [2:0] o, input logic [63:0] x,
                       input logic [63:0] y, input logic [4:0] m);
    int ca, cb; bit na, nb, sn, t; real va, vb; string req;
    @(negedge clk);
    dbl = dp; op = o; a = x; b = y; mask = m;
    ca = cls(x, dp); cb = cls(y, dp);
    na = ca >= 4; nb = cb >= 4; sn = (ca == 5) || (cb == 5);
    va = val(x, dp); vb = val(y, dp);
    case (o)
      3'd0: begin t = !(na || nb) && (va == vb);  req = (na || nb) ? "R6" : "R7"; end
      3'd1: begin t = !(na || nb) && (va > vb);   req = (na || nb) ? "R6" : "R7"; end
      3'd2: begin t = !(na || nb) && (va >= vb);  req = (na || nb) ? "R6" : "R7"; end
      3'd3: begin t = na || nb;                   req = "R5"; end
      3'd4: begin t = m[ca >= 4 ? 4 : ca];        req = "R3"; end
      default: begin t = 1'b0;                    req = "R2"; end
    endcase
    if (sn && o <= 3'd2) req = "R8";
    @(negedge clk);
    check(req, t ? 8'hFF : 8'h00, (o <= 3'd2) && sn);
  endtask

  initial begin
    #5;
    check("R10", 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    check("R10", 8'h00, 1'b0);
    rst_n = 1'b1;
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < NP; i++) begin
        for (int j = 0; j < NP; j++) begin
          for (int o = 0; o < 8; o++) begin
            if (o == 4) continue;
            apply(p[0], 3'(o), pat(i, p[0]), pat(j, p[0]), 5'd0);
          end
        end
        for (int m = 0; m < 32; m++) apply(p[0], 3'd4, pat(i, p[0]), pat(0, p[0]), 5'(m));
      end
    end
    // R1: predicate is full-width ones; R9: single ignores bit 63 junk sign
    apply(1'b0, 3'd0, 64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_3F80_0000, 5'd0);
    apply(1'b0, 3'd1, 64'h8000_0000_4000_0000, 64'h7FFF_FFFF_3F80_0000, 5'd0);
    // R10: reset mid-run clears registered result
    @(negedge clk); dbl = 1'b0; op = 3'd3; a = 64'h7FC0_0000; b = '0;
    @(negedge clk); rst_n = 1'b0;
    #1 check("R10", 8'h00, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R10", 8'hFF, 1'b0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule